// File: doc/BRIEF.md
# Multi-Class Circuit Admission Controller

This block decides whether a new fixed-rate circuit may be added to a shared upstream channel. It supports several circuit classes. Each class has a constant rate, given as a whole number of base bandwidth units. For each class the block keeps a count of active circuits, and from those counts it keeps the total bandwidth that circuits have reserved. A request names a class. The block admits it only when the reserved total plus that class's rate still fits under the circuit ceiling. Otherwise the request is blocked and no state changes.

The ceiling is a programmable input, and the block clamps it to the line rate. Admitted circuits do not start at once. Each one sits in a per-class staging count and moves into the active counts only at the next cycle boundary, marked by a pulse on `cycle_tick`. The partition planner reads `committed_bw`, which therefore never contains a circuit granted during the current polling cycle. Circuit releases arrive on their own plain strobe and remove active circuits only.

Requests use a valid/ready handshake. The decision is returned on a valid/ready output one clock after the request is accepted. `req_ready` is high when no decision is pending, or when the pending decision is being taken in the same clock. While the consumer holds `dec_ready` low, the decision stays stable and no new request is accepted.

Top module: `circuit_admit_ctrl`

## Requirements
- R1: After reset, all active and staged counts are zero, `committed_bw` and `rsv_bw` read 0, `dec_valid` and `rel_err` are low, and `req_ready` is high.
- R2: An accepted request of class k is admitted (`dec_admit`=1) exactly when the reserved total plus the class-k rate is less than or equal to the effective ceiling; an exact fit is admitted. A blocked request leaves every count unchanged.
- R3: The effective ceiling is `ceil_bw` clamped to LINE_RATE (64 units by default), so a ceiling programmed above the line rate admits no more than the line rate.
- R4: Class indices 0, 1 and 2 have rates 1, 3 and 12 units by default. A request with a class index of NUM_CLASSES or more is blocked.
- R5: An admission raises `rsv_bw` in the clock after acceptance. It reaches `committed_bw` only after the next clock with `cycle_tick` high. An admission accepted in the same clock as a tick waits for the following tick.
- R6: A release of class k with a nonzero active count decrements that count, and `committed_bw` and `rsv_bw` drop by the class-k rate in the next clock.
- R7: A release of a class whose active count is zero, or of a class index of NUM_CLASSES or more, changes no count and sets `rel_err`. `rel_err` stays set until reset.
- R8: When a release and an accepted request arrive in the same clock, the admission test uses the total with the release already removed.
- R9: `dec_valid` rises in the clock after a request is accepted (`req_valid` and `req_ready` both high). `dec_valid` and `dec_admit` hold while `dec_ready` is low. `req_ready` equals not `dec_valid`, or `dec_ready`.
- R10: `rsv_bw` always equals the rate-weighted sum of the active counts plus the staged counts, and `committed_bw` equals the rate-weighted sum of the active counts only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_tick | input | 1 | Polling cycle boundary pulse; moves staged admissions to active |
| ceil_bw | input | BW_W | Programmed circuit ceiling in base units |
| req_valid | input | 1 | Circuit request present |
| req_ready | output | 1 | Request can be accepted this clock |
| req_class | input | CLS_W | Class index of the request |
| dec_valid | output | 1 | Decision available |
| dec_ready | input | 1 | Consumer takes the decision |
| dec_admit | output | 1 | 1 = admitted, 0 = blocked |
| rel_valid | input | 1 | Circuit release strobe |
| rel_class | input | CLS_W | Class index of the release |
| committed_bw | output | BW_W | Bandwidth of active circuits, as seen by the partition planner |
| rsv_bw | output | BW_W | Bandwidth of active plus staged circuits |
| rel_err | output | 1 | Sticky flag for an ignored release |

## Verification
The checker tests several properties on every clock:
- an accepted admission never pushes the reserved total past the clamped ceiling;
- an out-of-range class is never admitted;
- `committed_bw` cannot move without a tick or a release;
- a pending decision stays frozen under back-pressure;
- the error flag is sticky;
- the committed total never exceeds the reserved total.

Other behaviours only the bench scenarios can show:
- that an exact fit at the ceiling is admitted while one unit more is blocked;
- that clamping to the line rate blocks a request a raw ceiling would have let through;
- that a release and a request in one clock are handled release first;
- that an admission made in a tick clock waits one more cycle before it reaches the planner's view.

// File: rtl/cac_pkg.sv
package cac_pkg;

  // Outcome of a release strobe in one clock
  typedef enum logic [1:0] {
    REL_IDLE   = 2'd0,
    REL_TAKE   = 2'd1,
    REL_REFUSE = 2'd2
  } rel_outcome_e;

  // Registered decision presented on the output stream
  typedef struct packed {
    logic valid;
    logic admit;
  } dec_t;

endpackage

// File: rtl/cac_class_slot.sv
// Per-class bookkeeping: active count and admissions staged for the next boundary.
module cac_class_slot #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rel_hit,
  input  logic             adm_hit,
  output logic [CNT_W-1:0] act_cnt,
  output logic [CNT_W-1:0] stg_cnt,
  output logic             rel_ok
);

  logic [CNT_W-1:0] act_q, stg_q;
  logic [CNT_W-1:0] act_d, stg_d;
  logic [CNT_W-1:0] act_less;

  // a release only removes a circuit that is already running
  assign rel_ok   = rel_hit && (act_q != '0);
  assign act_less = rel_ok ? (act_q - CNT_W'(1)) : act_q;

  always_comb begin
    act_d = tick ? (act_less + stg_q) : act_less;
    stg_d = tick ? '0 : stg_q;
    if (adm_hit) stg_d = stg_d + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      stg_q <= '0;
    end else begin
      act_q <= act_d;
      stg_q <= stg_d;
    end
  end

  assign act_cnt = act_q;
  assign stg_cnt = stg_q;

endmodule

// File: rtl/cac_weighted_sum.sv
// Rate-weighted sum of per-class counts.
module cac_weighted_sum #(
  parameter int                            NUM_CLASSES = 3,
  parameter int                            RATE_W      = 8,
  parameter int                            CNT_W       = 7,
  parameter int                            BW_W        = 7,
  parameter logic [NUM_CLASSES*RATE_W-1:0] CLASS_RATES = {8'd12, 8'd3, 8'd1}
) (
  input  logic [NUM_CLASSES*CNT_W-1:0] cnt_flat,
  output logic [BW_W-1:0]              total
);

  localparam int ACC_W = CNT_W + RATE_W + $clog2(NUM_CLASSES + 1);

  logic [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_CLASSES; k++) begin
      acc = acc + ACC_W'(cnt_flat[k*CNT_W +: CNT_W]) * ACC_W'(CLASS_RATES[k*RATE_W +: RATE_W]);
    end
  end

  assign total = BW_W'(acc);

endmodule

// File: rtl/cac_admit_judge.sv
// Knapsack fit test: post-release total plus the class rate against the clamped ceiling.
module cac_admit_judge #(
  parameter int BW_W      = 7,
  parameter int RATE_W    = 8,
  parameter int LINE_RATE = 64
) (
  input  logic [BW_W-1:0]   rsv_now,
  input  logic [BW_W-1:0]   rel_amt,
  input  logic [RATE_W-1:0] req_rate,
  input  logic [BW_W-1:0]   ceil_bw,
  output logic [BW_W-1:0]   rsv_after_rel,
  output logic              fits
);

  localparam int SUM_W = ((BW_W > RATE_W) ? BW_W : RATE_W) + 1;

  logic [BW_W-1:0]  ceil_eff;
  logic [SUM_W-1:0] need;

  assign ceil_eff      = (ceil_bw > BW_W'(LINE_RATE)) ? BW_W'(LINE_RATE) : ceil_bw;
  assign rsv_after_rel = rsv_now - rel_amt;
  assign need          = SUM_W'(rsv_after_rel) + SUM_W'(req_rate);
  assign fits          = (need <= SUM_W'(ceil_eff));

endmodule

// File: rtl/circuit_admit_ctrl.sv
module circuit_admit_ctrl
  import cac_pkg::*;
#(
  parameter int                            NUM_CLASSES = 3,
  parameter int                            RATE_W      = 8,
  parameter logic [NUM_CLASSES*RATE_W-1:0] CLASS_RATES = {8'd12, 8'd3, 8'd1},
  parameter int                            LINE_RATE   = 64,
  parameter int                            BW_W        = $clog2(LINE_RATE + 1),
  parameter int                            CLS_W       = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_tick,
  input  logic [BW_W-1:0]  ceil_bw,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CLS_W-1:0] req_class,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic             dec_admit,
  input  logic             rel_valid,
  input  logic [CLS_W-1:0] rel_class,
  output logic [BW_W-1:0]  committed_bw,
  output logic [BW_W-1:0]  rsv_bw,
  output logic             rel_err
);

  // every rate is at least one unit, so a count never exceeds the line rate
  localparam int CNT_W = BW_W;

  logic [NUM_CLASSES-1:0]       rel_hit, adm_hit, rel_ok;
  logic [NUM_CLASSES*CNT_W-1:0] act_flat, stg_flat;
  logic [RATE_W-1:0]            req_rate, rel_rate;
  logic [BW_W-1:0]              rsv_q, rsv_after_rel, rsv_d;
  logic                         req_fire, req_cls_ok, rel_cls_ok, fits, admit_now;
  dec_t                         dec_q;
  rel_outcome_e                 rel_out;
  logic                         err_q;

  assign req_cls_ok = ({1'b0, req_class} < (CLS_W+1)'(NUM_CLASSES));
  assign rel_cls_ok = ({1'b0, rel_class} < (CLS_W+1)'(NUM_CLASSES));

  // ---------------- request stream acceptance ----------------
  assign req_ready = !dec_q.valid || dec_ready;
  assign req_fire  = req_valid && req_ready;

  // ---------------- per-class slots ----------------
  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_slot
    assign rel_hit[g] = rel_valid && (rel_class == CLS_W'(g));
    assign adm_hit[g] = admit_now && (req_class == CLS_W'(g));

    cac_class_slot #(.CNT_W(CNT_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (cycle_tick),
      .rel_hit (rel_hit[g]),
      .adm_hit (adm_hit[g]),
      .act_cnt (act_flat[g*CNT_W +: CNT_W]),
      .stg_cnt (stg_flat[g*CNT_W +: CNT_W]),
      .rel_ok  (rel_ok[g])
    );
  end

  // ---------------- rate selection ----------------
  always_comb begin
    req_rate = '0;
    rel_rate = '0;
    for (int k = 0; k < NUM_CLASSES; k++) begin
      if (req_class == CLS_W'(k)) req_rate = CLASS_RATES[k*RATE_W +: RATE_W];
      if (rel_ok[k])              rel_rate = CLASS_RATES[k*RATE_W +: RATE_W];
    end
  end

  // ---------------- fit test (release applied first) ----------------
  cac_admit_judge #(
    .BW_W      (BW_W),
    .RATE_W    (RATE_W),
    .LINE_RATE (LINE_RATE)
  ) u_judge (
    .rsv_now       (rsv_q),
    .rel_amt       (BW_W'(rel_rate)),
    .req_rate      (req_rate),
    .ceil_bw       (ceil_bw),
    .rsv_after_rel (rsv_after_rel),
    .fits          (fits)
  );

  assign admit_now = req_fire && req_cls_ok && fits;
  assign rsv_d     = admit_now ? (rsv_after_rel + BW_W'(req_rate)) : rsv_after_rel;

  // ---------------- release outcome ----------------
  always_comb begin
    if (!rel_valid)                      rel_out = REL_IDLE;
    else if (rel_cls_ok && (|rel_ok))    rel_out = REL_TAKE;
    else                                 rel_out = REL_REFUSE;
  end

  // ---------------- state registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_q <= '0;
      dec_q <= '0;
      err_q <= 1'b0;
    end else begin
      rsv_q <= rsv_d;
      if (req_fire) begin
        dec_q.valid <= 1'b1;
        dec_q.admit <= admit_now;
      end else if (dec_ready) begin
        dec_q.valid <= 1'b0;
      end
      if (rel_out == REL_REFUSE) err_q <= 1'b1;
    end
  end

  // ---------------- planner view ----------------
  cac_weighted_sum #(
    .NUM_CLASSES (NUM_CLASSES),
    .RATE_W      (RATE_W),
    .CNT_W       (CNT_W),
    .BW_W        (BW_W),
    .CLASS_RATES (CLASS_RATES)
  ) u_commit_sum (
    .cnt_flat (act_flat),
    .total    (committed_bw)
  );

  assign rsv_bw    = rsv_q;
  assign dec_valid = dec_q.valid;
  assign dec_admit = dec_q.admit;
  assign rel_err   = err_q;

endmodule

// File: rtl/cac_checker.sv
module cac_checker #(
  parameter int NUM_CLASSES = 3,
  parameter int LINE_RATE   = 64,
  parameter int BW_W        = 7,
  parameter int CLS_W       = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cycle_tick,
  input logic [BW_W-1:0]  ceil_bw,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CLS_W-1:0] req_class,
  input logic             dec_valid,
  input logic             dec_ready,
  input logic             dec_admit,
  input logic             rel_valid,
  input logic [BW_W-1:0]  committed_bw,
  input logic [BW_W-1:0]  rsv_bw,
  input logic             rel_err
);

  logic [BW_W-1:0] cap;
  assign cap = (ceil_bw > BW_W'(LINE_RATE)) ? BW_W'(LINE_RATE) : ceil_bw;

  // R2
  admit_under_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!dec_admit || (rsv_bw <= $past(cap))));

  // R4
  bad_class_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ({1'b0, req_class} >= (CLS_W+1)'(NUM_CLASSES))) |=> !dec_admit);

  // R5
  commit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycle_tick && !rel_valid) |=> $stable(committed_bw));

  // R6
  release_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !cycle_tick) |=> (committed_bw <= $past(committed_bw)));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err);

  // R9
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_admit)));

  // R10
  commit_le_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    committed_bw <= rsv_bw);

endmodule

bind circuit_admit_ctrl cac_checker #(
  .NUM_CLASSES (NUM_CLASSES),
  .LINE_RATE   (LINE_RATE),
  .BW_W        (BW_W),
  .CLS_W       (CLS_W)
) u_cac_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cycle_tick   (cycle_tick),
  .ceil_bw      (ceil_bw),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_class    (req_class),
  .dec_valid    (dec_valid),
  .dec_ready    (dec_ready),
  .dec_admit    (dec_admit),
  .rel_valid    (rel_valid),
  .committed_bw (committed_bw),
  .rsv_bw       (rsv_bw),
  .rel_err      (rel_err)
);

// File: tb/circuit_admit_ctrl_tb.sv
`timescale 1ns/1ps
module circuit_admit_ctrl_tb;

  localparam int NCLS = 3;
  localparam int LINE = 64;
  localparam int RATE [NCLS] = '{1, 3, 12};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cycle_tick = 1'b0;
  logic [6:0] ceil_bw = 7'd100;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_class = 2'd0;
  logic       dec_valid;
  logic       dec_ready = 1'b1;
  logic       dec_admit;
  logic       rel_valid = 1'b0;
  logic [1:0] rel_class = 2'd0;
  logic [6:0] committed_bw;
  logic [6:0] rsv_bw;
  logic       rel_err;

  int n_chk = 0;
  int n_fail = 0;

  int m_act [NCLS];
  int m_stg [NCLS];
  bit m_dv = 0;
  bit m_da = 0;
  bit m_err = 0;

  always #2 clk = ~clk;

  circuit_admit_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cycle_tick   (cycle_tick),
    .ceil_bw      (ceil_bw),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_class    (req_class),
    .dec_valid    (dec_valid),
    .dec_ready    (dec_ready),
    .dec_admit    (dec_admit),
    .rel_valid    (rel_valid),
    .rel_class    (rel_class),
    .committed_bw (committed_bw),
    .rsv_bw       (rsv_bw),
    .rel_err      (rel_err)
  );

  function automatic int model_com();
    int s = 0;
    for (int k = 0; k < NCLS; k++) s += m_act[k] * RATE[k];
    return s;
  endfunction

  function automatic int model_rsv();
    int s = 0;
    for (int k = 0; k < NCLS; k++) s += (m_act[k] + m_stg[k]) * RATE[k];
    return s;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One clock: drive at negedge, predict, sample one time unit after the edge.
  task automatic step(bit rv, int rc, bit lv, int lc, bit tk, bit dr);
    bit fire, adm, take;
    int cap, rate_rc;
    req_valid  = rv;
    req_class  = rc[1:0];
    rel_valid  = lv;
    rel_class  = lc[1:0];
    cycle_tick = tk;
    dec_ready  = dr;
    #1;
    chk("R9 req_ready", int'(req_ready), int'(!m_dv || dr));
    fire = rv && (!m_dv || dr);
    take = 0;
    if (lv && lc < NCLS) take = (m_act[lc] > 0);
    if (lv && !take) m_err = 1;
    if (take) m_act[lc]--;
    cap = (ceil_bw > LINE) ? LINE : int'(ceil_bw);
    rate_rc = (rc < NCLS) ? RATE[rc] : 0;
    adm = fire && (rc < NCLS) && (model_rsv() + rate_rc <= cap);
    if (tk) begin
      for (int k = 0; k < NCLS; k++) begin
        m_act[k] += m_stg[k];
        m_stg[k] = 0;
      end
    end
    if (adm) m_stg[rc]++;
    if (fire) begin
      m_dv = 1;
      m_da = adm;
    end else if (dr) begin
      m_dv = 0;
    end
    @(posedge clk);
    #1;
    chk("R9 dec_valid", int'(dec_valid), int'(m_dv));
    if (m_dv) chk("R2 dec_admit", int'(dec_admit), int'(m_da));
    chk("R5 committed_bw", int'(committed_bw), model_com());
    chk("R10 rsv_bw", int'(rsv_bw), model_rsv());
    chk("R7 rel_err", int'(rel_err), int'(m_err));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < NCLS; k++) begin
      m_act[k] = 0;
      m_stg[k] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 committed_bw", int'(committed_bw), 0);
    chk("R1 rsv_bw", int'(rsv_bw), 0);
    chk("R1 dec_valid", int'(dec_valid), 0);
    chk("R1 rel_err", int'(rel_err), 0);
    chk("R1 req_ready", int'(req_ready), 1);

    // R3: ceiling 100 is clamped to 64; five class-2 circuits fill 60
    for (int i = 0; i < 5; i++) step(1, 2, 0, 0, 0, 1);
    step(1, 2, 0, 0, 0, 1);
    chk("R3 clamp blocks 72", int'(dec_admit), 0);
    // R2 exact fit at the ceiling admitted, one more unit blocked
    step(1, 1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 1);
    chk("R2 exact fit", int'(dec_admit), 1);
    step(1, 0, 0, 0, 0, 1);
    chk("R2 over by one", int'(dec_admit), 0);
    chk("R5 not yet committed", int'(committed_bw), 0);
    step(0, 0, 0, 0, 1, 1);
    chk("R5 committed after tick", int'(committed_bw), 64);

    // R8 release and request of class 2 in one clock
    step(1, 2, 1, 2, 0, 1);
    chk("R8 release first", int'(dec_admit), 1);
    chk("R6 committed after release", int'(committed_bw), 52);
    // R6 release class 1
    step(0, 0, 1, 1, 0, 1);
    chk("R6 committed drops by 3", int'(committed_bw), 49);
    // R7 release of empty class 1 ignored
    step(0, 0, 1, 1, 0, 1);
    chk("R7 err set", int'(rel_err), 1);
    chk("R7 committed kept", int'(committed_bw), 49);
    // R4 invalid class index
    step(1, 3, 1, 3, 0, 1);
    chk("R4 invalid class blocked", int'(dec_admit), 0);
    // R5 admission in a tick clock waits for the next tick
    step(1, 0, 0, 0, 1, 1);
    chk("R5 tick moves old staged", int'(committed_bw), 61);
    chk("R5 new admit still staged", int'(rsv_bw), 62);
    // R9 back-pressure: decision held, requests not taken
    step(1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    chk("R9 held decision", int'(dec_admit), 1);
    chk("R9 no new admit", int'(rsv_bw), 62);
    step(0, 0, 0, 0, 0, 1);
    chk("R9 drained", int'(dec_valid), 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 50) == 0) ceil_bw = 7'($urandom % 100);
      step(bit'($urandom % 2), int'($urandom % 4), bit'(($urandom % 4) == 0),
           int'($urandom % 4), bit'(($urandom % 8) == 0), bit'(($urandom % 4) != 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule